// File: doc/BRIEF.md
# Eight-Bit Addressable Storage Latch

This block holds eight single-bit values that are written one at a time through a 3-bit address and a single data pin. Its outputs appear together on an 8-bit parallel bus. An active-low enable and an active-high clear are decoded together into four operating modes:

- **Addressed write:** one bit is updated and the others are left alone.
- **Hold:** nothing changes.
- **One-of-eight demultiplex:** the addressed bit carries the data and every other bit is driven low.
- **Global clear:** all bits are zeroed.

Stepping the address from 0 to 7 while writing turns a serial bit stream into a parallel byte.

Every input is sampled on the rising clock edge, and storage changes only on that edge. An address that moves through intermediate codes between edges therefore can never write a wrong bit. The outputs are the storage register itself, so each mode's effect appears one clock after the inputs that select it. When demultiplex mode ends, the register keeps what it showed: the addressed bit holds the last data value and the other bits hold zero.

Top module: `addr_latch8`

## Requirements
- R1: When `rst` is high at a rising edge, all eight bits of `q` are 0 after that edge.
- R2: With `en_n`=0 and `clr`=0 at an edge, `q[addr]` takes the value of `din` after that edge.
- R3: With `en_n`=0 and `clr`=0 at an edge, every bit of `q` other than `q[addr]` keeps its value across that edge.
- R4: With `en_n`=1 and `clr`=0 at an edge, `q` is unchanged after that edge whatever `din` and `addr` are.
- R5: With `en_n`=0 and `clr`=1 at an edge, `q[addr]` equals `din` after that edge and all other bits are 0, so at most one bit is set.
- R6: With `en_n`=1 and `clr`=1 at an edge, `q` is all zeros after that edge.
- R7: After demultiplex mode is left for hold mode, `q` keeps the demultiplexed pattern: the last addressed bit equals the last data value and the other bits are 0.
- R8: Address value k selects output bit k, with bit 0 as the least significant bit of `q`.
- R9: Eight consecutive addressed writes with `addr` stepping from 0 to 7 and `din` carrying bit k of a byte at step k leave that byte on `q`.
- R10: Reset takes priority over every mode of `en_n` and `clr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears storage |
| en_n | input | 1 | Active-low enable |
| clr | input | 1 | Active-high clear / demultiplex select |
| addr | input | 3 | Bit select, 0 to 7 |
| din | input | 1 | Data bit written to the addressed position |
| q | output | 8 | Stored bits, bit k selected by address k |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge and changes only between edges. They also assume that reset is applied before the first checked edge.

The stimulus keeps to these assumptions. It holds reset high from time zero, and it drives inputs only on falling edges. It picks them from a fixed-seed random source, so multi-bit address jumps are legal and expected. Directed sequences add mode changes in every order, a reset during each mode, and a full serial byte load.

// File: rtl/latch8_pkg.sv
package latch8_pkg;

  typedef enum logic [1:0] {
    MODE_WRITE = 2'b00,
    MODE_HOLD  = 2'b01,
    MODE_DEMUX = 2'b10,
    MODE_CLEAR = 2'b11
  } latch_mode_e;

  function automatic latch_mode_e decode_mode(input logic en_n, input logic clr);
    return latch_mode_e'({clr, en_n});
  endfunction

endpackage

// File: rtl/latch8_mode_dec.sv
module latch8_mode_dec
  import latch8_pkg::*;
(
  input  logic        en_n,
  input  logic        clr,
  output latch_mode_e mode
);
  always_comb mode = decode_mode(en_n, clr);
endmodule

// File: rtl/latch8_addr_dec.sv
module latch8_addr_dec #(
  parameter int ADDR_W = 3,
  localparam int N_BITS = 1 << ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [N_BITS-1:0] sel
);
  for (genvar k = 0; k < N_BITS; k++) begin : g_sel
    assign sel[k] = (addr == ADDR_W'(k));
  end
endmodule

// File: rtl/latch8_store.sv
module latch8_store
  import latch8_pkg::*;
#(
  parameter int N_BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  latch_mode_e       mode,
  input  logic [N_BITS-1:0] sel,
  input  logic              din,
  output logic [N_BITS-1:0] bits
);
  for (genvar k = 0; k < N_BITS; k++) begin : g_bit
    logic nxt;
    always_comb begin
      unique case (mode)
        MODE_WRITE: nxt = sel[k] ? din : bits[k];
        MODE_HOLD:  nxt = bits[k];
        MODE_DEMUX: nxt = sel[k] & din;
        default:    nxt = 1'b0;
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) bits[k] <= 1'b0;
      else     bits[k] <= nxt;
    end
  end
endmodule

// File: rtl/addr_latch8.sv
module addr_latch8
  import latch8_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int N_BITS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_n,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              din,
  output logic [N_BITS-1:0] q
);
  latch_mode_e       mode;
  logic [N_BITS-1:0] sel;

  latch8_mode_dec u_mode (.en_n(en_n), .clr(clr), .mode(mode));

  latch8_addr_dec #(.ADDR_W(ADDR_W)) u_adec (.addr(addr), .sel(sel));

  latch8_store #(.N_BITS(N_BITS)) u_store (
    .clk(clk), .rst(rst), .mode(mode), .sel(sel), .din(din), .bits(q)
  );
endmodule

// File: rtl/addr_latch8_chk.sv
module addr_latch8_chk #(
  parameter int ADDR_W = 3,
  localparam int N_BITS = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rst,
  input logic              en_n,
  input logic              clr,
  input logic [ADDR_W-1:0] addr,
  input logic              din,
  input logic [N_BITS-1:0] q
);
  localparam logic [N_BITS-1:0] ONE = 1;

  assert_reset_clears_R1: assert property (@(posedge clk) rst |=> q == '0);

  assert_write_bit_R2: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr) |=> q[$past(addr)] == $past(din));

  assert_write_others_R3: assert property (@(posedge clk) disable iff (rst)
    (!en_n && !clr) |=> (q & ~(ONE << $past(addr))) == ($past(q) & ~(ONE << $past(addr))));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (en_n && !clr) |=> $stable(q));

  assert_demux_R5: assert property (@(posedge clk) disable iff (rst)
    (!en_n && clr) |=> ($countones(q) <= 1) && q[$past(addr)] == $past(din));

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (en_n && clr) |=> q == '0);
endmodule

bind addr_latch8 addr_latch8_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .en_n(en_n), .clr(clr), .addr(addr), .din(din), .q(q)
);

// File: tb/addr_latch8_tb.sv
module addr_latch8_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_n = 1'b1;
  logic       clr = 1'b0;
  logic [2:0] addr = '0;
  logic       din = 1'b0;
  logic [7:0] q;
  logic [7:0] model = '0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_latch8 u_dut (.clk(clk), .rst(rst), .en_n(en_n), .clr(clr),
                     .addr(addr), .din(din), .q(q));

  function automatic logic [7:0] ref_next(logic [7:0] cur, logic r, logic e_n,
                                          logic c, logic [2:0] a, logic d);
    logic [7:0] n;
    n = cur;
    if (r) return 8'h00;
    case ({c, e_n})
      2'b00: n[a] = d;
      2'b01: n = cur;
      2'b10: begin n = 8'h00; n[a] = d; end
      default: n = 8'h00;
    endcase
    return n;
  endfunction

  task automatic check(string tag);
    checks++;
    if (q !== model) begin
      fails++;
      $display("FAIL %s: q=%02h expected=%02h", tag, q, model);
    end
  endtask

  // Drive at falling edge, let one rising edge pass, compare after it.
  task automatic step(logic r, logic e_n, logic c, logic [2:0] a, logic d, string tag);
    rst = r; en_n = e_n; clr = c; addr = a; din = d;
    model = ref_next(model, r, e_n, c, a, d);
    @(posedge clk);
    #1;
    check(tag);
    @(negedge clk);
  endtask

  function automatic string mode_tag(logic e_n, logic c);
    case ({c, e_n})
      2'b00: return "R2_R3_write";
      2'b01: return "R4_hold";
      2'b10: return "R5_demux";
      default: return "R6_clear";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: expired expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    @(negedge clk);
    step(1, 0, 0, 3'd4, 1, "R1_reset");
    step(0, 1, 0, 3'd0, 0, "R4_idle");
    // R8: address 5 lands on bit 5
    step(0, 0, 0, 3'd5, 1, "R8_bitpos");
    step(0, 1, 0, 3'd2, 1, "R4_hold_ignores_din");
    // R10: reset wins in each mode
    for (int m = 0; m < 4; m++) begin
      step(0, 0, 0, 3'(m + 1), 1, "R2_prefill");
      step(1, m[0], m[1], 3'(m + 1), 1, "R10_reset_priority");
    end
    // R9: serial to parallel of 0xA5
    for (int k = 0; k < 8; k++) step(0, 0, 0, 3'(k), 1'((8'hA5 >> k) & 1), "R9_serial");
    step(0, 1, 0, 3'd0, 0, "R9_byte_held");
    // R7: demux then hold
    step(0, 0, 1, 3'd6, 1, "R5_demux");
    step(0, 1, 0, 3'd1, 0, "R7_after_demux");
    step(0, 1, 0, 3'd3, 1, "R7_after_demux2");
    // all mode-to-mode transitions for every address
    for (int a = 0; a < 8; a++)
      for (int m1 = 0; m1 < 4; m1++)
        for (int m2 = 0; m2 < 4; m2++) begin
          step(0, m1[0], m1[1], 3'(a), 1'($urandom & 1), mode_tag(m1[0], m1[1]));
          step(0, m2[0], m2[1], 3'(7 - a), 1'($urandom & 1), mode_tag(m2[0], m2[1]));
        end
    // constrained random: mostly writes and holds
    for (int i = 0; i < 3000; i++) begin
      int p;
      logic e_n, c;
      p = int'($urandom % 16);
      e_n = (p >= 6 && p < 11) || p >= 14;
      c = p >= 11;
      step(0, e_n, c, 3'($urandom), 1'($urandom), mode_tag(e_n, c));
    end
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule